// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits on a byte-wide camera pixel stream and finds the synchronization markers embedded in it. A marker is three fixed preamble bytes followed by one code byte. The code byte is compared against four codes held in a configuration word: frame start, frame end, line start and line end. Each recognised code raises a single-cycle event pulse. A frame-active flag follows the frame start and frame end events.

Every byte that belongs to a marker is removed from the pass-through stream. The remaining bytes are forwarded, one cycle late, only while a frame is open. Two configuration values act as wildcards. An all-ones frame-end code turns every otherwise unmatched code into a frame end. An all-ones frame-start code switches off frame-start recognition. In that mode a line start that arrives while no frame is open opens the frame.

Top module: `esc_sync_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, every event output, frame_active_o and pix_valid_o are 0.
- R2: A marker is the byte sequence 0xFF, 0x00, 0x00, code, counted over valid cycles only. The codes sit in codes_cfg as follows: frame start in bits 7:0, line start in bits 15:8, line end in bits 23:16, frame end in bits 31:24. When the code byte is consumed at a clock edge, the matching event output is high for exactly the one cycle after that edge.
- R3: Cycles with din_valid low neither advance nor reset the preamble matcher, and they produce no events.
- R4: The matcher resynchronizes on overlapping input. For example, 0xFF 0xFF 0x00 0x00 code is detected, with the last 0xFF taken as the start of the preamble.
- R5: A code byte that matches no programmed code, with no wildcard mode in force, produces no event. The matcher then returns to idle.
- R6: When several codes are equal, one event fires, chosen in this order: frame start, frame end, line start, line end.
- R7: When the frame-end code is 0xFF, a code byte equal to none of the frame-start, line-start and line-end codes gives a frame-end event.
- R8: When the frame-start code is 0xFF, no byte is ever recognised as a frame-start code. A line-start code consumed while no frame is active raises both frame_start_o and line_start_o.
- R9: frame_active_o becomes 1 in the same cycle as a frame_start_o pulse. It becomes 0 in the same cycle as a frame_end_o pulse. Otherwise it holds its value.
- R10: A valid byte is forwarded on pix_valid_o/pix_data_o one cycle after it is consumed, but only if frame_active_o was 1 when it arrived and the byte is not a sync byte. Sync bytes are: any 0xFF; a 0x00 that follows a pending 0xFF or 0xFF 0x00; and any code byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Stream byte |
| din_valid | input | 1 | Byte-valid strobe |
| codes_cfg | input | 32 | Four programmed codes (see R2) |
| frame_start_o | output | 1 | Frame start event pulse |
| frame_end_o | output | 1 | Frame end event pulse |
| line_start_o | output | 1 | Line start event pulse |
| line_end_o | output | 1 | Line end event pulse |
| frame_active_o | output | 1 | A frame is open |
| pix_valid_o | output | 1 | Forwarded byte is valid |
| pix_data_o | output | 8 | Forwarded byte |

## Verification
The bench targets several corner cases, each tied to a specific failure. Preambles are interrupted by idle cycles; a matcher that clears on an idle cycle would miss those markers. Repeated 0xFF bytes come before a preamble; a matcher that returns to idle on the second 0xFF would lose the marker. Configurations with duplicate codes and with each wildcard are used. A wrong priority would raise two events, or the wrong one. A wrong wildcard would miss frame ends, or would report frame starts from an all-ones code. Random streams check that marker bytes never leak into the pixel output and that no pixels pass outside a frame.

// File: rtl/esc_pkg.sv
// Shared types for the embedded sync code decoder.
// Assumes byte-wide codes; the marker preamble is 0xFF 0x00 0x00.
package esc_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_FF     = 2'd1,
        M_FF00   = 2'd2,
        M_FF0000 = 2'd3
    } match_st_t;

    typedef struct packed {
        logic fs;
        logic fe;
        logic ls;
        logic le;
    } sync_evt_t;
endpackage

// File: rtl/esc_preamble_match.sv
// Preamble matcher: tracks 0xFF 0x00 0x00 over valid bytes.
// Flags the code byte and every byte that is part of a marker.
// Assumes din is only meaningful when din_valid is high.
module esc_preamble_match
    import esc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         din_valid,
    output logic         code_strobe,
    output logic         sync_byte
);
    localparam logic [W-1:0] ONES  = {W{1'b1}};
    localparam logic [W-1:0] ZEROS = {W{1'b0}};

    match_st_t st_q, st_d;

    // Next matcher state for the byte on din.
    always_comb begin
        st_d = st_q;
        if (din_valid) begin
            if (st_q == M_FF0000)        st_d = M_IDLE;
            else if (din == ONES)        st_d = M_FF;
            else if (din == ZEROS && st_q == M_FF)   st_d = M_FF00;
            else if (din == ZEROS && st_q == M_FF00) st_d = M_FF0000;
            else                         st_d = M_IDLE;
        end
    end

    // Matcher state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= M_IDLE;
        else        st_q <= st_d;
    end

    // Code byte is the valid byte after a full preamble.
    assign code_strobe = din_valid && (st_q == M_FF0000);

    // Marker bytes are held back from the pass-through path.
    assign sync_byte = din_valid &&
                       ((st_q == M_FF0000) || (din == ONES) ||
                        (din == ZEROS && (st_q == M_FF || st_q == M_FF00)));

    // R3: idle cycles leave the matcher alone.
    assert_idle_holds_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |=> $stable(st_q));

    // R5: after any code byte the matcher is idle.
    assert_code_returns_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_strobe |=> (st_q == M_IDLE));
endmodule

// File: rtl/esc_code_classify.sv
// Code classifier: maps a code byte to at most one event class
// (plus an implied frame start in the disabled-start mode).
// Pure combinational; assumes code_strobe marks a real code byte.
module esc_code_classify
    import esc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic [W-1:0]   code,
    input  logic           code_strobe,
    input  logic [4*W-1:0] codes_cfg,
    input  logic           frame_active,
    output sync_evt_t      hits
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [W-1:0] c_fs, c_ls, c_le, c_fe;
    logic fs_dis, fe_wild;
    logic fs_m, fe_m, ls_m, le_m;

    assign c_fs = codes_cfg[0*W +: W];
    assign c_ls = codes_cfg[1*W +: W];
    assign c_le = codes_cfg[2*W +: W];
    assign c_fe = codes_cfg[3*W +: W];

    assign fs_dis  = (c_fs == ONES);
    assign fe_wild = (c_fe == ONES);

    // Priority compare: start, end, line start, line end.
    always_comb begin
        fs_m = code_strobe && !fs_dis && (code == c_fs);
        fe_m = code_strobe && !fs_m &&
               ((code == c_fe) ||
                (fe_wild && code != c_fs && code != c_ls && code != c_le));
        ls_m = code_strobe && !fs_m && !fe_m && (code == c_ls);
        le_m = code_strobe && !fs_m && !fe_m && !ls_m && (code == c_le);
        hits.fs = fs_m || (fs_dis && ls_m && !frame_active);
        hits.fe = fe_m;
        hits.ls = ls_m;
        hits.le = le_m;
    end
endmodule

// File: rtl/esc_frame_track.sv
// Event and frame tracker: registers the event pulses, keeps the
// frame-active flag and forwards in-frame non-marker bytes.
// Assumes hits are at most one class besides a paired fs/ls.
module esc_frame_track
    import esc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sync_evt_t    hits,
    input  logic [W-1:0] din,
    input  logic         din_valid,
    input  logic         sync_byte,
    output sync_evt_t    evt_q,
    output logic         active_q,
    output logic         pix_valid_q,
    output logic [W-1:0] pix_data_q
);
    // Event pulses, frame state and forwarded byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q       <= '0;
            active_q    <= 1'b0;
            pix_valid_q <= 1'b0;
            pix_data_q  <= '0;
        end else begin
            evt_q       <= hits;
            if (hits.fs)      active_q <= 1'b1;
            else if (hits.fe) active_q <= 1'b0;
            pix_valid_q <= din_valid && !sync_byte && active_q;
            if (din_valid) pix_data_q <= din;
        end
    end

    // R2: each event lasts one cycle (markers are 4 bytes apart).
    assert_event_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q != '0) |=> (evt_q == '0));

    // R9: active follows start and end pulses.
    assert_active_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.fs |-> active_q);
    assert_inactive_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.fe |-> !active_q);
endmodule

// File: rtl/esc_sync_decoder.sv
// Embedded sync code decoder top: matcher, classifier and tracker.
// Assumes codes_cfg is stable while markers are in flight.
module esc_sync_decoder
    import esc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   din,
    input  logic           din_valid,
    input  logic [4*W-1:0] codes_cfg,
    output logic           frame_start_o,
    output logic           frame_end_o,
    output logic           line_start_o,
    output logic           line_end_o,
    output logic           frame_active_o,
    output logic           pix_valid_o,
    output logic [W-1:0]   pix_data_o
);
    logic      code_strobe, sync_byte;
    sync_evt_t hits, evt_q;

    esc_preamble_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .code_strobe(code_strobe), .sync_byte(sync_byte)
    );

    esc_code_classify #(.W(W)) u_class (
        .code(din), .code_strobe(code_strobe), .codes_cfg(codes_cfg),
        .frame_active(frame_active_o), .hits(hits)
    );

    esc_frame_track #(.W(W)) u_track (
        .clk(clk), .rst_n(rst_n), .hits(hits), .din(din),
        .din_valid(din_valid), .sync_byte(sync_byte), .evt_q(evt_q),
        .active_q(frame_active_o), .pix_valid_q(pix_valid_o),
        .pix_data_q(pix_data_o)
    );

    assign frame_start_o = evt_q.fs;
    assign frame_end_o   = evt_q.fe;
    assign line_start_o  = evt_q.ls;
    assign line_end_o    = evt_q.le;

    // R6: only one class fires (start may pair with line start).
    assert_single_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start_o, frame_end_o, line_end_o}) &&
        !(frame_end_o && line_start_o) && !(line_end_o && line_start_o));

    // R3: no event unless a byte was consumed at the previous edge.
    assert_event_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o || frame_end_o || line_start_o || line_end_o) |-> $past(din_valid));

    // R10: forwarded bytes arrive only from an open frame.
    assert_pass_needs_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> ($past(frame_active_o) && $past(din_valid)));
endmodule

// File: tb/esc_sync_decoder_tb_top.sv
module esc_sync_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic [31:0] codes_cfg = '0;
    logic fs_o, fe_o, ls_o, le_o, act_o, pv_o;
    logic [7:0] pd_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    int  m_st  = 0;
    bit  m_act = 0;

    always #2 clk = ~clk;

    esc_sync_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .codes_cfg(codes_cfg), .frame_start_o(fs_o), .frame_end_o(fe_o),
        .line_start_o(ls_o), .line_end_o(le_o), .frame_active_o(act_o),
        .pix_valid_o(pv_o), .pix_data_o(pd_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected event bits {fs,fe,ls,le} for a code byte.
    function automatic logic [3:0] ref_class(input logic [7:0] c, input logic [31:0] cfg, input bit act);
        logic [7:0] s, l, e, f;
        bit hs, he, hl, hd;
        s = cfg[7:0]; l = cfg[15:8]; e = cfg[23:16]; f = cfg[31:24];
        hs = (s != 8'hFF) && (c == s);
        he = !hs && ((c == f) || (f == 8'hFF && c != s && c != l && c != e));
        hl = !hs && !he && (c == l);
        hd = !hs && !he && !hl && (c == e);
        if (s == 8'hFF && hl && !act) hs = 1'b1;
        return {hs, he, hl, hd};
    endfunction

    task automatic send(input logic [7:0] b, input bit v, input string tag);
        logic [3:0] exp_ev;
        bit supp, exp_pv;
        @(negedge clk);
        din = b; din_valid = v;
        exp_ev = 4'b0;
        supp = v && (b == 8'hFF || m_st == 3 || (b == 8'h00 && (m_st == 1 || m_st == 2)));
        exp_pv = v && !supp && m_act;
        if (v && m_st == 3) exp_ev = ref_class(b, codes_cfg, m_act);
        if (v) begin
            if (m_st == 3) m_st = 0;
            else if (b == 8'hFF) m_st = 1;
            else if (b == 8'h00 && (m_st == 1 || m_st == 2)) m_st = m_st + 1;
            else m_st = 0;
        end
        if (exp_ev[3]) m_act = 1;
        else if (exp_ev[2]) m_act = 0;
        @(posedge clk); #1;
        check({fs_o, fe_o, ls_o, le_o} == exp_ev, tag, {fs_o, fe_o, ls_o, le_o}, exp_ev);
        check(act_o == m_act, "R9 frame_active", act_o, m_act);
        check(pv_o == exp_pv, "R10 pix_valid", pv_o, exp_pv);
        if (exp_pv) check(pd_o == b, "R10 pix_data", pd_o, b);
    endtask

    task automatic marker(input logic [7:0] c, input string tag);
        send(8'hFF, 1, tag); send(8'h00, 1, tag); send(8'h00, 1, tag); send(c, 1, tag);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        codes_cfg = {8'hB6, 8'h9D, 8'h80, 8'hAB}; // fe, le, ls, fs
        repeat (3) @(posedge clk);
        #1;
        check({fs_o, fe_o, ls_o, le_o, act_o, pv_o} == 6'b0, "R1 in reset", {fs_o, fe_o, ls_o, le_o, act_o, pv_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check({fs_o, fe_o, ls_o, le_o, act_o, pv_o} == 6'b0, "R1 after release", {fs_o, fe_o, ls_o, le_o, act_o, pv_o}, 0);

        // R2 basic frame with pixels.
        marker(8'hAB, "R2 frame start");
        send(8'h12, 1, "R10 pixel"); send(8'h34, 1, "R10 pixel");
        marker(8'h80, "R2 line start");
        send(8'h55, 1, "R10 pixel");
        marker(8'h9D, "R2 line end");
        // R3 gaps inside a preamble.
        send(8'hFF, 1, "R3"); send(8'h00, 0, "R3"); send(8'h00, 1, "R3");
        send(8'h11, 0, "R3"); send(8'h00, 1, "R3"); send(8'h77, 0, "R3");
        send(8'h80, 1, "R3 gap line start");
        // R4 overlapping preambles.
        send(8'hFF, 1, "R4"); send(8'hFF, 1, "R4"); marker(8'h9D, "R4 resync");
        send(8'hFF, 1, "R4"); send(8'h00, 1, "R4"); marker(8'h80, "R4 resync after FF00");
        // R5 unknown code.
        marker(8'h42, "R5 unknown code");
        send(8'h00, 1, "R5 idle after"); send(8'h00, 1, "R5"); send(8'h80, 1, "R5 no false hit");
        marker(8'hB6, "R2 frame end");
        send(8'h21, 1, "R10 outside frame");
        // R6 duplicates.
        codes_cfg = {8'h33, 8'h33, 8'h33, 8'h33};
        marker(8'h33, "R6 start wins");
        codes_cfg = {8'h44, 8'h33, 8'h33, 8'h10};
        marker(8'h44, "R6 end"); marker(8'h33, "R6 line start over line end");
        // R7 wildcard frame end.
        codes_cfg = {8'hFF, 8'h9D, 8'h80, 8'hAB};
        marker(8'hAB, "R7 start"); marker(8'h80, "R7 line start kept");
        marker(8'h9D, "R7 line end kept"); marker(8'h5A, "R7 wildcard end");
        // R8 disabled frame start.
        codes_cfg = {8'hB6, 8'h9D, 8'h80, 8'hFF};
        marker(8'hFF, "R8 all-ones not start");
        marker(8'h80, "R8 implied start");
        marker(8'h80, "R8 plain line start");
        marker(8'hB6, "R8 end"); marker(8'h9D, "R8 line end no start");
        marker(8'h80, "R8 start after end");

        // Random phase.
        for (int blk = 0; blk < 6; blk++) begin
            case (blk)
                0: codes_cfg = {8'hB6, 8'h9D, 8'h80, 8'hAB};
                1: codes_cfg = {8'hFF, 8'h9D, 8'h80, 8'hAB};
                2: codes_cfg = {8'hB6, 8'h9D, 8'h80, 8'hFF};
                3: codes_cfg = {8'hFF, 8'h9D, 8'h80, 8'hFF};
                4: codes_cfg = {8'h80, 8'h9D, 8'h80, 8'hAB};
                default: codes_cfg = $urandom;
            endcase
            for (int i = 0; i < 600; i++) begin
                logic [7:0] b;
                int r;
                r = $urandom_range(0, 9);
                case (r)
                    0, 1: b = 8'hFF;
                    2, 3: b = 8'h00;
                    4: b = codes_cfg[7:0];
                    5: b = codes_cfg[15:8];
                    6: b = codes_cfg[23:16];
                    7: b = codes_cfg[31:24];
                    default: b = $urandom;
                endcase
                send(b, ($urandom_range(0, 4) != 0), "R2 random stream");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule